// File: doc/BRIEF.md
# ADC Output Frame Assembler

This block turns one conversion result plus a set of status and configuration fields into a single serial frame of variable length. A 32-bit control word, written one byte at a time, selects which optional fields are placed after the data word, whether the data word is replaced by a fixed test pattern, and whether two even-parity bits close the frame.

A frame-start strobe captures the control word and every input field together. The frame is then shifted out MSB first, one bit for each serial tick. A done pulse marks the end of the frame. Changes made while a frame is in flight only affect the next frame.

Top module: `adc_frame_serializer`

## Requirements
- R1: After reset the control word reads back as zero in all four bytes, `sdo` is 0, `frame_busy` is 0 and `frame_done` is 0.
- R2: Control bytes sit at addresses 0x10 (bits 7:0), 0x11, 0x12 and 0x13 (bits 31:24). A write with `reg_we` high updates only the byte it addresses. `reg_rdata` shows the addressed byte one cycle after `reg_addr` is presented. Only bits 14, 13:12, 11:10, 8, 3 and 2:0 are writable; all other bits, and every address outside 0x10 to 0x13, read as 0.
- R3: Control bits 2:0 choose the data word: 0xx sends `conv_data`, 100 sends all zeros, 101 sends all ones, 110 sends 1010… and 111 sends 1100…, both counted from the data-word MSB.
- R4: The frame is sent in this order: the data word MSB first, then the 4-bit `dev_addr` if bit 14 is set, then supply flags, then input flags, then the 4-bit `range_code` if bit 8 is set. Bits 13:12 (supply) and 11:10 (input) encode 01 as the high flag only, 10 as the low flag only and 11 as both, with high sent before low.
- R5: With bit 3 set, two bits close the frame. The first is even parity over the data word as sent. The second is even parity over the data word and all included fields; it does not cover the first parity bit.
- R6: The frame length is DATA_W + 4·bit14 + popcount(bits 13:12) + popcount(bits 11:10) + 4·bit8 + 2·bit3.
- R7: A `frame_start` while idle puts the first frame bit on `sdo` and raises `frame_busy` on the next cycle. Each `shift_tick` advances one bit. The tick that ends the last bit raises `frame_done` for exactly one cycle, drops `frame_busy` and returns `sdo` to 0.
- R8: While a frame is in flight, `frame_start` is ignored. Changes to the control word or the input fields do not alter the bits still to be sent, and `sdo` holds between ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Control byte write strobe |
| reg_addr | input | 8 | Control byte address |
| reg_wdata | input | 8 | Control byte write data |
| reg_rdata | output | 8 | Registered read data of the addressed byte |
| conv_data | input | DATA_W | Conversion result |
| dev_addr | input | 4 | Device address field |
| sup_hi | input | 1 | Supply high alarm flag |
| sup_lo | input | 1 | Supply low alarm flag |
| in_hi | input | 1 | Input high alarm flag |
| in_lo | input | 1 | Input low alarm flag |
| range_code | input | 4 | Input range setting field |
| frame_start | input | 1 | Frame start strobe |
| shift_tick | input | 1 | Advance one serial bit |
| sdo | output | 1 | Serial data, MSB first |
| frame_busy | output | 1 | Frame in flight |
| frame_done | output | 1 | One-cycle pulse after the last bit |

## Verification
The assertions assume that `frame_start` and `shift_tick` are plain single-cycle strobes, and that nothing drives a register byte in the same cycle as the start it should affect. The bench writes control bytes only in cycles of their own. In the gaps between ticks of a running frame it deliberately changes inputs, rewrites control bytes and pulses `frame_start`, so that the ignore rules are exercised while the frame is held. Ticks arrive with random gaps of zero to two idle cycles. Every frame is compared bit by bit against a model built from the requirements.

// File: rtl/afs_pkg.sv
package afs_pkg;
  // extra bits beyond the data word: dev addr 4, supply 2, input 2, range 4, parity 2
  localparam int EXTRA_W = 14;
  localparam logic [31:0] CFG_MASK = 32'h0000_7D0F;

  typedef struct packed {
    logic       dev_inc;
    logic [1:0] sup_sel;
    logic [1:0] in_sel;
    logic       rng_inc;
    logic       par_en;
    logic [2:0] dsel;
  } cfg_t;
endpackage

// File: rtl/afs_cfg_regs.sv
module afs_cfg_regs
  import afs_pkg::*;
#(
  parameter int              AW        = 8,
  parameter logic [AW-1:0]   BASE_ADDR = 8'h10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata,
  output cfg_t          cfg
);
  localparam int NLANE = 4;

  logic [31:0] cfg_q;
  logic        hit;
  logic [1:0]  lane;

  assign hit  = (addr >= BASE_ADDR) && (addr < BASE_ADDR + AW'(NLANE));
  assign lane = addr[1:0] - BASE_ADDR[1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= '0;
      rdata <= '0;
    end else begin
      for (int g = 0; g < NLANE; g++) begin
        if (we && hit && (lane == 2'(g)))
          cfg_q[8*g +: 8] <= wdata & CFG_MASK[8*g +: 8];
      end
      rdata <= hit ? cfg_q[8*lane +: 8] : 8'h00;
    end
  end

  assign cfg.dev_inc = cfg_q[14];
  assign cfg.sup_sel = cfg_q[13:12];
  assign cfg.in_sel  = cfg_q[11:10];
  assign cfg.rng_inc = cfg_q[8];
  assign cfg.par_en  = cfg_q[3];
  assign cfg.dsel    = cfg_q[2:0];

  AST_TOP_BYTE_ZERO: assert property (@(posedge clk) disable iff (rst)
    (addr == BASE_ADDR + AW'(3)) |=> (rdata == 8'h00)); // R2
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
    !hit |=> (rdata == 8'h00)); // R2
endmodule

// File: rtl/afs_frame_build.sv
module afs_frame_build
  import afs_pkg::*;
#(
  parameter int DW   = 18,
  parameter int MAXW = DW + afs_pkg::EXTRA_W,
  parameter int LW   = $clog2(MAXW + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  cfg_t            cfg,
  input  logic [DW-1:0]   conv,
  input  logic [3:0]      dev,
  input  logic            sup_hi,
  input  logic            sup_lo,
  input  logic            in_hi,
  input  logic            in_lo,
  input  logic [3:0]      rng,
  output logic [MAXW-1:0] frame,
  output logic [LW-1:0]   len
);
  logic [DW-1:0]   word;
  logic [MAXW-1:0] acc;
  logic            dpar;
  logic            fpar;

  // data word selection, patterns counted from the MSB
  always_comb begin
    for (int j = 0; j < DW; j++) begin
      if (!cfg.dsel[2]) begin
        word[j] = conv[j];
      end else begin
        case (cfg.dsel[1:0])
          2'b00:   word[j] = 1'b0;
          2'b01:   word[j] = 1'b1;
          2'b10:   word[j] = (((DW - 1 - j) % 2) == 0);
          default: word[j] = ((((DW - 1 - j) / 2) % 2) == 0);
        endcase
      end
    end
  end

  // append fields at the LSB end, then left-align
  always_comb begin
    acc  = MAXW'(word);
    len  = LW'(DW);
    dpar = ^word;
    fpar = ^word;
    if (cfg.dev_inc) begin
      acc  = {acc[MAXW-5:0], dev};
      len  = len + LW'(4);
      fpar = fpar ^ (^dev);
    end
    if (cfg.sup_sel[0]) begin
      acc  = {acc[MAXW-2:0], sup_hi};
      len  = len + LW'(1);
      fpar = fpar ^ sup_hi;
    end
    if (cfg.sup_sel[1]) begin
      acc  = {acc[MAXW-2:0], sup_lo};
      len  = len + LW'(1);
      fpar = fpar ^ sup_lo;
    end
    if (cfg.in_sel[0]) begin
      acc  = {acc[MAXW-2:0], in_hi};
      len  = len + LW'(1);
      fpar = fpar ^ in_hi;
    end
    if (cfg.in_sel[1]) begin
      acc  = {acc[MAXW-2:0], in_lo};
      len  = len + LW'(1);
      fpar = fpar ^ in_lo;
    end
    if (cfg.rng_inc) begin
      acc  = {acc[MAXW-5:0], rng};
      len  = len + LW'(4);
      fpar = fpar ^ (^rng);
    end
    if (cfg.par_en) begin
      acc  = {acc[MAXW-3:0], dpar, fpar};
      len  = len + LW'(2);
    end
    frame = acc << (LW'(MAXW) - len);
  end

  AST_LEN_BOUNDS: assert property (@(posedge clk) disable iff (rst)
    (len >= LW'(DW)) && (len <= LW'(MAXW))); // R6
  AST_PAR_ADDS_TWO: assert property (@(posedge clk) disable iff (rst)
    cfg.par_en |-> (len >= LW'(DW + 2))); // R6
endmodule

// File: rtl/afs_shifter.sv
module afs_shifter #(
  parameter int MAXW = 32,
  parameter int LW   = $clog2(MAXW + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  logic [MAXW-1:0] load_frame,
  input  logic [LW-1:0]   load_len,
  input  logic            tick,
  output logic            sdo,
  output logic            busy,
  output logic            done
);
  logic [MAXW-1:0] sh;
  logic [LW-1:0]   cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh   <= '0;
      cnt  <= '0;
      sdo  <= 1'b0;
      busy <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy && load) begin
        sdo  <= load_frame[MAXW-1];
        sh   <= load_frame << 1;
        cnt  <= load_len;
        busy <= 1'b1;
      end else if (busy && tick) begin
        if (cnt == LW'(1)) begin
          sdo  <= 1'b0;
          busy <= 1'b0;
          done <= 1'b1;
          cnt  <= '0;
        end else begin
          sdo <= sh[MAXW-1];
          sh  <= sh << 1;
          cnt <= cnt - LW'(1);
        end
      end
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R7
  AST_DONE_AT_END: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done); // R7
  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !sdo); // R7
  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (rst)
    (busy && !tick) |=> (busy && $stable(cnt) && $stable(sdo))); // R8
endmodule

// File: rtl/adc_frame_serializer.sv
module adc_frame_serializer
  import afs_pkg::*;
#(
  parameter int DATA_W = 18
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [7:0]        reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic [DATA_W-1:0] conv_data,
  input  logic [3:0]        dev_addr,
  input  logic              sup_hi,
  input  logic              sup_lo,
  input  logic              in_hi,
  input  logic              in_lo,
  input  logic [3:0]        range_code,
  input  logic              frame_start,
  input  logic              shift_tick,
  output logic              sdo,
  output logic              frame_busy,
  output logic              frame_done
);
  localparam int MAXW = DATA_W + EXTRA_W;
  localparam int LW   = $clog2(MAXW + 1);

  cfg_t            cfg;
  logic [MAXW-1:0] frame;
  logic [LW-1:0]   len;

  afs_cfg_regs #(.AW(8), .BASE_ADDR(8'h10)) u_regs (
    .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .cfg(cfg)
  );

  afs_frame_build #(.DW(DATA_W), .MAXW(MAXW), .LW(LW)) u_build (
    .clk(clk), .rst(rst), .cfg(cfg), .conv(conv_data), .dev(dev_addr),
    .sup_hi(sup_hi), .sup_lo(sup_lo), .in_hi(in_hi), .in_lo(in_lo),
    .rng(range_code), .frame(frame), .len(len)
  );

  afs_shifter #(.MAXW(MAXW), .LW(LW)) u_shift (
    .clk(clk), .rst(rst), .load(frame_start), .load_frame(frame),
    .load_len(len), .tick(shift_tick), .sdo(sdo), .busy(frame_busy),
    .done(frame_done)
  );

  AST_START_RAISES_BUSY: assert property (@(posedge clk) disable iff (rst)
    (frame_start && !frame_busy) |=> frame_busy); // R7
endmodule

// File: tb/sim_adc_frame_serializer.sv
module sim_adc_frame_serializer;
  localparam int DW   = 18;
  localparam int MAXW = DW + 14;
  localparam logic [31:0] MASK = 32'h0000_7D0F;

  logic clk = 0, rst = 1;
  logic reg_we = 0;
  logic [7:0] reg_addr = 0, reg_wdata = 0, reg_rdata;
  logic [DW-1:0] conv_data = 0;
  logic [3:0] dev_addr = 0, range_code = 0;
  logic sup_hi = 0, sup_lo = 0, in_hi = 0, in_lo = 0;
  logic frame_start = 0, shift_tick = 0;
  logic sdo, frame_busy, frame_done;

  int checks = 0, fails = 0;
  bit finished = 0;
  logic [31:0] shadow = 0;
  logic exp_bits [0:63];
  int exp_len;

  always #2.5 clk = ~clk;

  adc_frame_serializer #(.DATA_W(DW)) u0 (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .conv_data(conv_data),
    .dev_addr(dev_addr), .sup_hi(sup_hi), .sup_lo(sup_lo), .in_hi(in_hi),
    .in_lo(in_lo), .range_code(range_code), .frame_start(frame_start),
    .shift_tick(shift_tick), .sdo(sdo), .frame_busy(frame_busy),
    .frame_done(frame_done)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, expv, $time);
    end
  endtask

  task automatic push(input logic b);
    exp_bits[exp_len] = b;
    exp_len++;
  endtask

  // reference frame from R3..R6
  task automatic build_exp(input logic [31:0] c);
    logic b, dp, fp;
    exp_len = 0; dp = 0; fp = 0;
    for (int i = 0; i < DW; i++) begin
      if (!c[2]) b = conv_data[DW-1-i];
      else case (c[1:0])
        2'd0: b = 0;
        2'd1: b = 1;
        2'd2: b = (i % 2 == 0);
        default: b = ((i % 4) < 2);
      endcase
      dp ^= b; fp ^= b; push(b);
    end
    if (c[14]) for (int i = 3; i >= 0; i--) begin fp ^= dev_addr[i]; push(dev_addr[i]); end
    if (c[12]) begin fp ^= sup_hi; push(sup_hi); end
    if (c[13]) begin fp ^= sup_lo; push(sup_lo); end
    if (c[10]) begin fp ^= in_hi; push(in_hi); end
    if (c[11]) begin fp ^= in_lo; push(in_lo); end
    if (c[8]) for (int i = 3; i >= 0; i--) begin fp ^= range_code[i]; push(range_code[i]); end
    if (c[3]) begin push(dp); push(fp); end
  endtask

  task automatic wr_byte(input logic [7:0] a, input logic [7:0] d);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
    if (a >= 8'h10 && a <= 8'h13) shadow[8*(a-8'h10) +: 8] = d & MASK[8*(a-8'h10) +: 8];
  endtask

  task automatic rd_check(input logic [7:0] a);
    logic [7:0] e;
    reg_addr = a;
    @(negedge clk);
    e = (a >= 8'h10 && a <= 8'h13) ? shadow[8*(a-8'h10) +: 8] : 8'h00;
    check("R2 readback", reg_rdata, e);
  endtask

  task automatic write_cfg(input logic [31:0] v);
    for (int i = 0; i < 4; i++) wr_byte(8'h10 + 8'(i), v[8*i +: 8]);
    wr_byte(8'h14, 8'hFF);
    wr_byte(8'h0F, 8'hFF);
    for (int i = 0; i < 4; i++) rd_check(8'h10 + 8'(i));
    rd_check(8'h14);
  endtask

  task automatic rand_inputs();
    conv_data = DW'($urandom);
    dev_addr = 4'($urandom); range_code = 4'($urandom);
    {sup_hi, sup_lo, in_hi, in_lo} = 4'($urandom);
  endtask

  task automatic run_frame();
    rand_inputs();
    build_exp(shadow);
    check("R6 length formula", 64'(exp_len),
          64'(DW + 4*shadow[14] + shadow[13] + shadow[12] + shadow[11] + shadow[10]
              + 4*shadow[8] + 2*shadow[3]));
    frame_start = 1;
    @(negedge clk);
    frame_start = 0;
    check("R7 busy after start", frame_busy, 1);
    check("R3/R4 first bit", sdo, exp_bits[0]);
    for (int k = 1; k <= exp_len; k++) begin
      int gaps = int'($urandom % 3);
      for (int g = 0; g < gaps; g++) begin
        rand_inputs();
        frame_start = $urandom % 2;
        if ($urandom % 3 == 0) begin
          reg_we = 1; reg_addr = 8'h10 + 8'($urandom % 4); reg_wdata = 8'($urandom);
        end
        @(negedge clk);
        frame_start = 0;
        if (reg_we) begin
          reg_we = 0;
          shadow[8*(reg_addr-8'h10) +: 8] = reg_wdata & MASK[8*(reg_addr-8'h10) +: 8];
        end
        check("R8 hold busy", frame_busy, 1);
        check("R8 hold sdo", sdo, exp_bits[k-1]);
      end
      shift_tick = 1;
      @(negedge clk);
      shift_tick = 0;
      if (k < exp_len) begin
        check("R3/R4/R5 frame bit", sdo, exp_bits[k]);
      end else begin
        check("R7 done pulse", frame_done, 1);
        check("R7 busy drops", frame_busy, 0);
        check("R7 sdo idle", sdo, 0);
      end
    end
    @(negedge clk);
    check("R7 done one cycle", frame_done, 0);
  endtask

  initial begin
    logic [31:0] directed [6];
    directed = '{32'h0000_0000, 32'h0000_7D0F, 32'h0000_400C,
                 32'h0000_0105, 32'h0000_1406, 32'h0000_2B0B};
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check("R1 sdo reset", sdo, 0);
    check("R1 busy reset", frame_busy, 0);
    check("R1 done reset", frame_done, 0);
    for (int i = 0; i < 4; i++) rd_check(8'h10 + 8'(i));
    for (int i = 0; i < 6; i++) begin
      write_cfg(directed[i]);
      run_frame();
    end
    for (int i = 0; i < 40; i++) begin
      write_cfg($urandom);
      run_frame();
      run_frame();
    end
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule